// File: doc/BRIEF.md
# Daisy-Chained Input Serializer Readout Controller

This block is an SPI master that pulls a whole chain of input serializers through one chip-select frame. Each device in the chain presents eight digital inputs. In status mode each device also sends a status byte, which carries a 5-bit check code over its input byte and bits for overtemperature and supply undervoltage. The controller sorts the received bytes by device. It checks each device's diagnostics and its external fault line. It then reports, for each device, whether the eight inputs can be trusted. A device that is not trusted has its inputs forced to zero, and the healthy devices around it are still reported.

A single `start` strobe begins a frame. The serial clock comes from the system clock through a parameterised divider. When the frame ends, all results are loaded together, and a one-cycle `done` pulse marks the update. The number of devices, the framing mode, the number of fault lines (one shared or one per device) and the clock divider are all parameters. The `ign_uv` input makes the block ignore the undervoltage flags and the fault line, for chains that are supplied so that they always report undervoltage.

Top module: `ser_chain_rdr`

## Requirements
- R1: One frame holds exactly N_DEV×8 serial clock rising edges with no status bytes, and N_DEV×16 with status bytes. All of them fall inside a single low period of `cs_n`, and `cs_n` stays low for exactly 2×SCK_DIV system clocks per bit.
- R2: Bits are received MSB first. With status bytes, device d's input byte is received byte 2d and its status byte is byte 2d+1; without status bytes, device d's input byte is byte d. Device d's inputs appear at `in_vec[8d+7:8d]`.
- R3: With status bytes, `crc_err[d]` is set when status bits 7:3 differ from the CRC of the input byte. The CRC uses the generator x^5+x^4+x^2+1, starts from zero and processes the byte MSB first.
- R4: With status bytes, `over_temp[d]` equals status bit 1. While `ign_uv` is 0, `uv_alarm[d]` is the inverse of status bit 2 and `uv_warn[d]` is the inverse of status bit 0.
- R5: While `ign_uv` is 1, `uv_alarm`, `uv_warn` and `fault_seen` read 0 and have no effect on validity. The CRC and overtemperature checks still apply.
- R6: A device is untrusted when `fault_seen`, `crc_err`, `over_temp` or `uv_alarm` is set for it. An untrusted device has `dev_ok[d]=0` and `in_vec` bits for it at zero, while its neighbours are still reported. `uv_warn` alone leaves the device trusted.
- R7: Without status bytes, `crc_err`, `over_temp`, `uv_alarm` and `uv_warn` read 0, and the fault line is the only diagnostic.
- R8: With FAULT_W=1, `fault_in[0]` applies to every device. With FAULT_W=N_DEV, device d uses `fault_in[d]`. A line's level is sampled at the end of the frame.
- R9: `done` is a one-cycle pulse after `cs_n` has returned high. All result outputs change only in the cycle `done` is high. A `start` that arrives while a frame is in progress is ignored. After reset all results read 0.
- R10: `sck` is low whenever `cs_n` is high. Each half period of `sck` lasts SCK_DIV system clocks. Serial data is sampled on the rising edge of `sck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one readout frame (ignored while busy) |
| ign_uv | input | 1 | Disregard undervoltage flags and fault lines |
| fault_in | input | FAULT_W | Fault lines, shared or one per device, active high |
| miso | input | 1 | Serial data from the chain |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| in_vec | output | N_DEV*8 | Input bits of all devices, zero for untrusted devices |
| crc_err | output | N_DEV | Per-device check-code mismatch |
| over_temp | output | N_DEV | Per-device overtemperature |
| uv_alarm | output | N_DEV | Per-device undervoltage alarm |
| uv_warn | output | N_DEV | Per-device undervoltage warning |
| fault_seen | output | N_DEV | Per-device fault line state |
| dev_ok | output | N_DEV | Per-device inputs trusted |
| done | output | 1 | One-cycle pulse when results update |

## Verification
Two instances are tested: a three-device chain with status bytes and one fault line per device, and a three-device chain without status bytes that shares a single fault line. The status-mode patterns cover a fully healthy chain, then a chain with one corrupted check code in the middle device. Further patterns put overtemperature on the first device and an undervoltage alarm on the last, give only a warning on the middle device, and raise a fault line on one device only. Together these show that every diagnostic masks only its own device, and that a warning alone does not mask. Two patterns tell the masking effect of `ign_uv` apart from the checks it must leave alone: a chain with undervoltage, a fault line and a check-code error is read with `ign_uv` set, and a chain with the shared fault line raised is read with and without it. Byte-order mistakes show up because every device carries a distinct input byte. A second `start` pulse in the middle of a frame shows whether busy-time strobes are ignored.

// File: rtl/ser_chain_pkg.sv
package ser_chain_pkg;

   localparam int BYTE_W = 8;
   // generator x^5+x^4+x^2+1, top-aligned in an 8-bit register
   localparam logic [7:0] CRC_TAP = 8'hA8;

   typedef struct packed {
      logic crc;
      logic hot;
      logic uva;
      logic uvw;
      logic flt;
   } dev_flags_t;

   function automatic logic [4:0] crc5_of(input logic [7:0] d);
      logic [7:0] r;
      r = d;
      for (int k = 0; k < BYTE_W; k++) begin
         r = r[7] ? ({r[6:0], 1'b0} ^ CRC_TAP) : {r[6:0], 1'b0};
      end
      return r[7:3];
   endfunction

endpackage

// File: rtl/ser_chain_judge.sv
module ser_chain_judge
   import ser_chain_pkg::*;
#(
   parameter bit STATUS_BYTE = 1'b1
) (
   input  logic       [7:0] in_b,
   input  logic       [7:0] st_b,
   input  logic             pin_flt,
   input  logic             ign_uv,
   output dev_flags_t       flags,
   output logic             trusted,
   output logic       [7:0] data_o
);

   localparam logic HAS_ST = STATUS_BYTE;

   always_comb begin
      flags.crc = HAS_ST && (st_b[7:3] != crc5_of(in_b));
      flags.hot = HAS_ST && st_b[1];
      flags.uva = HAS_ST && !ign_uv && !st_b[2];
      flags.uvw = HAS_ST && !ign_uv && !st_b[0];
      flags.flt = !ign_uv && pin_flt;
      trusted   = !(flags.flt || flags.crc || flags.hot || flags.uva);
      data_o    = trusted ? in_b : 8'h00;
   end

endmodule

// File: rtl/ser_chain_shift.sv
module ser_chain_shift #(
   parameter int TOT_BITS = 48,
   parameter int SCK_DIV  = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                miso,
   output logic                sck,
   output logic                cs_n,
   output logic [TOT_BITS-1:0] frame,
   output logic                frame_vld
);

   localparam int DIV_W = (SCK_DIV > 1) ? $clog2(SCK_DIV) : 1;
   localparam int BIT_W = $clog2(TOT_BITS + 1);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCK_DIV - 1);
   localparam logic [BIT_W-1:0] BIT_END  = BIT_W'(TOT_BITS);

   typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_END} st_t;

   st_t             st;
   logic [DIV_W-1:0] div_q;
   logic [BIT_W-1:0] nbit_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= S_IDLE;
         sck       <= 1'b0;
         cs_n      <= 1'b1;
         div_q     <= '0;
         nbit_q    <= '0;
         frame     <= '0;
         frame_vld <= 1'b0;
      end else begin
         frame_vld <= 1'b0;
         case (st)
            S_IDLE: begin
               if (start) begin
                  st     <= S_SHIFT;
                  cs_n   <= 1'b0;
                  div_q  <= '0;
                  nbit_q <= '0;
               end
            end
            S_SHIFT: begin
               if (div_q == DIV_LAST) begin
                  div_q <= '0;
                  if (!sck) begin
                     sck    <= 1'b1;
                     frame  <= {frame[TOT_BITS-2:0], miso};
                     nbit_q <= nbit_q + 1'b1;
                  end else begin
                     sck <= 1'b0;
                     if (nbit_q == BIT_END) begin
                        st   <= S_END;
                        cs_n <= 1'b1;
                     end
                  end
               end else begin
                  div_q <= div_q + 1'b1;
               end
            end
            S_END: begin
               frame_vld <= 1'b1;
               st        <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ser_chain_rdr.sv
module ser_chain_rdr
   import ser_chain_pkg::*;
#(
   parameter int N_DEV       = 3,
   parameter bit STATUS_BYTE = 1'b1,
   parameter int FAULT_W     = N_DEV,
   parameter int SCK_DIV     = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     ign_uv,
   input  logic [FAULT_W-1:0]       fault_in,
   input  logic                     miso,
   output logic                     sck,
   output logic                     cs_n,
   output logic [N_DEV*BYTE_W-1:0]  in_vec,
   output logic [N_DEV-1:0]         crc_err,
   output logic [N_DEV-1:0]         over_temp,
   output logic [N_DEV-1:0]         uv_alarm,
   output logic [N_DEV-1:0]         uv_warn,
   output logic [N_DEV-1:0]         fault_seen,
   output logic [N_DEV-1:0]         dev_ok,
   output logic                     done
);

   localparam int WORD_B   = STATUS_BYTE ? 2 : 1;
   localparam int STRIDE   = WORD_B * BYTE_W;
   localparam int TOT_BITS = N_DEV * STRIDE;
   localparam int VEC_W    = N_DEV * BYTE_W;

   if (N_DEV < 1) begin : g_bad_ndev
      $error("N_DEV must be at least 1");
   end
   if (FAULT_W != 1 && FAULT_W != N_DEV) begin : g_bad_fault
      $error("FAULT_W must be 1 or N_DEV");
   end
   if (SCK_DIV < 1) begin : g_bad_div
      $error("SCK_DIV must be at least 1");
   end

   logic [TOT_BITS-1:0] frame;
   logic                frame_vld;

   ser_chain_shift #(
      .TOT_BITS (TOT_BITS),
      .SCK_DIV  (SCK_DIV)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .miso      (miso),
      .sck       (sck),
      .cs_n      (cs_n),
      .frame     (frame),
      .frame_vld (frame_vld)
   );

   logic [VEC_W-1:0] j_data;
   logic [N_DEV-1:0] j_crc, j_hot, j_uva, j_uvw, j_flt, j_ok;

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      localparam int IB = TOT_BITS - 1 - d * STRIDE;
      logic [7:0]  in_b, st_b;
      logic        pin;
      dev_flags_t  fl;

      assign in_b = frame[IB -: BYTE_W];
      if (STATUS_BYTE) begin : g_st
         assign st_b = frame[IB-BYTE_W -: BYTE_W];
      end else begin : g_nost
         assign st_b = 8'hFF;
      end
      if (FAULT_W == 1) begin : g_shared
         assign pin = fault_in[0];
      end else begin : g_own
         assign pin = fault_in[d];
      end

      ser_chain_judge #(
         .STATUS_BYTE (STATUS_BYTE)
      ) u_judge (
         .in_b    (in_b),
         .st_b    (st_b),
         .pin_flt (pin),
         .ign_uv  (ign_uv),
         .flags   (fl),
         .trusted (j_ok[d]),
         .data_o  (j_data[d*BYTE_W +: BYTE_W])
      );

      assign j_crc[d] = fl.crc;
      assign j_hot[d] = fl.hot;
      assign j_uva[d] = fl.uva;
      assign j_uvw[d] = fl.uvw;
      assign j_flt[d] = fl.flt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_vec     <= '0;
         crc_err    <= '0;
         over_temp  <= '0;
         uv_alarm   <= '0;
         uv_warn    <= '0;
         fault_seen <= '0;
         dev_ok     <= '0;
         done       <= 1'b0;
      end else begin
         done <= frame_vld;
         if (frame_vld) begin
            in_vec     <= j_data;
            crc_err    <= j_crc;
            over_temp  <= j_hot;
            uv_alarm   <= j_uva;
            uv_warn    <= j_uvw;
            fault_seen <= j_flt;
            dev_ok     <= j_ok;
         end
      end
   end

endmodule

// File: rtl/ser_chain_chk.sv
module ser_chain_chk #(
   parameter int N_DEV       = 3,
   parameter bit STATUS_BYTE = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ign_uv,
   input logic               sck,
   input logic               cs_n,
   input logic               done,
   input logic [N_DEV*8-1:0] in_vec,
   input logic [N_DEV-1:0]   crc_err,
   input logic [N_DEV-1:0]   over_temp,
   input logic [N_DEV-1:0]   uv_alarm,
   input logic [N_DEV-1:0]   uv_warn,
   input logic [N_DEV-1:0]   fault_seen,
   input logic [N_DEV-1:0]   dev_ok
);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(in_vec) && $stable(dev_ok) && $stable(crc_err) &&
                 $stable(over_temp) && $stable(uv_alarm) && $stable(uv_warn) &&
                 $stable(fault_seen)));

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);

   p_sck_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck);

   p_ign_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(ign_uv)) |-> (uv_alarm == '0 && uv_warn == '0 && fault_seen == '0));

   for (genvar d = 0; d < N_DEV; d++) begin : g_dev
      p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !dev_ok[d] |-> (in_vec[d*8 +: 8] == 8'h00));
      p_faultmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (done && fault_seen[d]) |-> !dev_ok[d]);
      if (STATUS_BYTE) begin : g_st
         p_warn_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (done && uv_warn[d] && !crc_err[d] && !over_temp[d] && !uv_alarm[d] &&
             !fault_seen[d]) |-> dev_ok[d]);
      end
   end

   if (!STATUS_BYTE) begin : g_nost
      p_no_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
         done |-> (crc_err == '0 && over_temp == '0 && uv_alarm == '0 && uv_warn == '0));
   end

endmodule

bind ser_chain_rdr ser_chain_chk #(
   .N_DEV       (N_DEV),
   .STATUS_BYTE (STATUS_BYTE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ign_uv     (ign_uv),
   .sck        (sck),
   .cs_n       (cs_n),
   .done       (done),
   .in_vec     (in_vec),
   .crc_err    (crc_err),
   .over_temp  (over_temp),
   .uv_alarm   (uv_alarm),
   .uv_warn    (uv_warn),
   .fault_seen (fault_seen),
   .dev_ok     (dev_ok)
);

// File: tb/tb_ser_chain_rdr.sv
module tb_chain_slave #(
   parameter int TOT = 48
) (
   input  logic           sck,
   input  logic           cs_n,
   input  logic [TOT-1:0] bits,
   output logic           miso,
   output int             rises
);
   int idx;
   initial begin
      idx   = 0;
      miso  = 1'b0;
      rises = 0;
   end
   always @(negedge cs_n) begin
      idx   = 0;
      rises = 0;
      miso  = bits[TOT-1];
   end
   always @(negedge sck) begin
      if (!cs_n) begin
         idx++;
         if (idx < TOT) miso = bits[TOT-1-idx];
      end
   end
   always @(posedge sck) begin
      if (!cs_n) rises++;
   end
endmodule

module tb_ser_chain_rdr;

   localparam int ND     = 3;
   localparam int DIV_A  = 2;
   localparam int DIV_B  = 1;
   localparam int TOT_A  = ND * 16;
   localparam int TOT_B  = ND * 8;
   localparam int LOW_A  = 2 * DIV_A * TOT_A;
   localparam int LOW_B  = 2 * DIV_B * TOT_B;

   typedef struct {
      logic [ND*8-1:0] ins;
      logic [ND-1:0]   crc, hot, uva, uvw, flt, ok;
      string           tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   // instance A: status bytes, one fault line per device
   logic             start_a = 1'b0, ign_a = 1'b0, miso_a;
   logic [ND-1:0]    flt_a = '0;
   logic [TOT_A-1:0] frame_a = '0;
   logic             sck_a, cs_a, done_a;
   logic [ND*8-1:0]  vec_a;
   logic [ND-1:0]    crc_a, hot_a, uva_a, uvw_a, fs_a, ok_a;
   int               rises_a;

   // instance B: input bytes only, shared fault line
   logic             start_b = 1'b0, ign_b = 1'b0, miso_b;
   logic [0:0]       flt_b = '0;
   logic [TOT_B-1:0] frame_b = '0;
   logic             sck_b, cs_b, done_b;
   logic [ND*8-1:0]  vec_b;
   logic [ND-1:0]    crc_b, hot_b, uva_b, uvw_b, fs_b, ok_b;
   int               rises_b;

   ser_chain_rdr #(.N_DEV(ND), .STATUS_BYTE(1'b1), .FAULT_W(ND), .SCK_DIV(DIV_A)) dut (
      .clk(clk), .rst_n(rst_n), .start(start_a), .ign_uv(ign_a), .fault_in(flt_a),
      .miso(miso_a), .sck(sck_a), .cs_n(cs_a), .in_vec(vec_a), .crc_err(crc_a),
      .over_temp(hot_a), .uv_alarm(uva_a), .uv_warn(uvw_a), .fault_seen(fs_a),
      .dev_ok(ok_a), .done(done_a));

   ser_chain_rdr #(.N_DEV(ND), .STATUS_BYTE(1'b0), .FAULT_W(1), .SCK_DIV(DIV_B)) dut_b (
      .clk(clk), .rst_n(rst_n), .start(start_b), .ign_uv(ign_b), .fault_in(flt_b),
      .miso(miso_b), .sck(sck_b), .cs_n(cs_b), .in_vec(vec_b), .crc_err(crc_b),
      .over_temp(hot_b), .uv_alarm(uva_b), .uv_warn(uvw_b), .fault_seen(fs_b),
      .dev_ok(ok_b), .done(done_b));

   tb_chain_slave #(.TOT(TOT_A)) u_sl_a (.sck(sck_a), .cs_n(cs_a), .bits(frame_a), .miso(miso_a), .rises(rises_a));
   tb_chain_slave #(.TOT(TOT_B)) u_sl_b (.sck(sck_b), .cs_n(cs_b), .bits(frame_b), .miso(miso_b), .rises(rises_b));

   int   n_cmp = 0, n_bad = 0;
   int   n_exp_a = 0, n_exp_b = 0, n_done_a = 0, n_done_b = 0;
   exp_t qa[$], qb[$];

   task automatic chk(input bit good, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!good) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // remainder of byte*x^5 divided by x^5+x^4+x^2+1
   function automatic logic [4:0] crc_ref(input logic [7:0] b);
      logic [12:0] rem;
      rem = {b, 5'b0};
      for (int k = 12; k >= 5; k--) begin
         if (rem[k]) rem = rem ^ (13'b110101 << (k - 5));
      end
      return rem[4:0];
   endfunction

   function automatic logic [7:0] gst(input logic [7:0] b);
      return {crc_ref(b), 3'b101};
   endfunction

   function automatic exp_t model(input logic [0:ND-1][7:0] ib, input logic [0:ND-1][7:0] sb,
                                  input bit m16, input logic [ND-1:0] fp, input bit ign,
                                  input string tag);
      exp_t e;
      e.tag = tag;
      for (int d = 0; d < ND; d++) begin
         logic bad;
         e.crc[d] = m16 && (sb[d][7:3] != crc_ref(ib[d]));
         e.hot[d] = m16 && sb[d][1];
         e.uva[d] = m16 && !ign && !sb[d][2];
         e.uvw[d] = m16 && !ign && !sb[d][0];
         e.flt[d] = !ign && fp[d];
         bad = e.crc[d] | e.hot[d] | e.uva[d] | e.flt[d];
         e.ok[d] = !bad;
         e.ins[d*8 +: 8] = bad ? 8'h00 : ib[d];
      end
      return e;
   endfunction

   task automatic send_a(input logic [0:ND-1][7:0] ib, input logic [0:ND-1][7:0] sb,
                         input logic [ND-1:0] f, input bit ign, input bit dbl, input string tag);
      @(negedge clk);
      frame_a = {ib[0], sb[0], ib[1], sb[1], ib[2], sb[2]};
      flt_a   = f;
      ign_a   = ign;
      qa.push_back(model(ib, sb, 1'b1, f, ign, tag));
      n_exp_a++;
      start_a = 1'b1;
      @(negedge clk);
      start_a = 1'b0;
      if (dbl) begin
         repeat (20) @(negedge clk);
         start_a = 1'b1;   // mid-frame strobe, must be ignored (R9)
         @(negedge clk);
         start_a = 1'b0;
      end
      while (qa.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic send_b(input logic [0:ND-1][7:0] ib, input logic f, input bit ign,
                         input string tag);
      @(negedge clk);
      frame_b  = {ib[0], ib[1], ib[2]};
      flt_b[0] = f;
      ign_b    = ign;
      qb.push_back(model(ib, {8'hFF, 8'hFF, 8'hFF}, 1'b0, {ND{f}}, ign, tag));
      n_exp_b++;
      start_b = 1'b1;
      @(negedge clk);
      start_b = 1'b0;
      while (qb.size() != 0) @(negedge clk);
      repeat (4) @(negedge clk);
   endtask

   task automatic compare(input exp_t e, input logic [ND*8-1:0] v, input logic [ND-1:0] c,
                          input logic [ND-1:0] h, input logic [ND-1:0] ua, input logic [ND-1:0] uw,
                          input logic [ND-1:0] fs, input logic [ND-1:0] ok);
      chk(v  == e.ins, {e.tag, " R2"}, "in_vec",    32'(v),  32'(e.ins));
      chk(c  == e.crc, {e.tag, " R3"}, "crc_err",   32'(c),  32'(e.crc));
      chk(h  == e.hot, {e.tag, " R4"}, "over_temp", 32'(h),  32'(e.hot));
      chk(ua == e.uva, {e.tag, " R4"}, "uv_alarm",  32'(ua), 32'(e.uva));
      chk(uw == e.uvw, {e.tag, " R4"}, "uv_warn",   32'(uw), 32'(e.uvw));
      chk(fs == e.flt, {e.tag, " R8"}, "fault",     32'(fs), 32'(e.flt));
      chk(ok == e.ok,  {e.tag, " R6"}, "dev_ok",    32'(ok), 32'(e.ok));
   endtask

   // monitors: pop and compare on each done pulse
   int low_a = 0, low_b = 0;
   logic pd_a = 1'b0, pd_b = 1'b0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (!cs_a) low_a++;
         if (!cs_b) low_b++;
         if (done_a && pd_a) chk(1'b0, "R9", "done_a width", 32'd2, 32'd1);
         if (done_b && pd_b) chk(1'b0, "R9", "done_b width", 32'd2, 32'd1);
         if (done_a) begin
            n_done_a++;
            chk(low_a == LOW_A, "R10", "cs_a low cycles", 32'(low_a), 32'(LOW_A));
            chk(rises_a == TOT_A, "R1", "sck_a rises", 32'(rises_a), 32'(TOT_A));
            low_a = 0;
            if (qa.size() == 0) chk(1'b0, "R9", "unexpected done_a", 32'd1, 32'd0);
            else compare(qa.pop_front(), vec_a, crc_a, hot_a, uva_a, uvw_a, fs_a, ok_a);
         end
         if (done_b) begin
            n_done_b++;
            chk(low_b == LOW_B, "R10", "cs_b low cycles", 32'(low_b), 32'(LOW_B));
            chk(rises_b == TOT_B, "R1", "sck_b rises", 32'(rises_b), 32'(TOT_B));
            low_b = 0;
            if (qb.size() == 0) chk(1'b0, "R9", "unexpected done_b", 32'd1, 32'd0);
            else compare(qb.pop_front(), vec_b, crc_b, hot_b, uva_b, uvw_b, fs_b, ok_b);
         end
      end
      pd_a = done_a;
      pd_b = done_b;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R9, R10)
      chk(cs_a == 1'b1 && sck_a == 1'b0, "R10", "idle pins A", {30'd0, cs_a, sck_a}, 32'd2);
      chk(cs_b == 1'b1 && sck_b == 1'b0, "R10", "idle pins B", {30'd0, cs_b, sck_b}, 32'd2);
      chk(ok_a == '0 && vec_a == '0 && done_a == 1'b0, "R9", "reset results A", 32'(vec_a), 32'd0);
      chk(ok_b == '0 && vec_b == '0 && done_b == 1'b0, "R9", "reset results B", 32'(vec_b), 32'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2 R3: healthy chain, distinct bytes
      send_a({8'hA5, 8'h3C, 8'h81}, {gst(8'hA5), gst(8'h3C), gst(8'h81)}, 3'b000, 1'b0, 1'b0, "R2");
      // R3 R6: corrupted check code on the middle device only
      send_a({8'h5A, 8'hC3, 8'h7E}, {gst(8'h5A), gst(8'hC3) ^ 8'h08, gst(8'h7E)}, 3'b000, 1'b0, 1'b0, "R3");
      // R4: overtemperature on device 0, undervoltage alarm on device 2
      send_a({8'h11, 8'h22, 8'h44}, {gst(8'h11) | 8'h02, gst(8'h22), gst(8'h44) & 8'hFB}, 3'b000, 1'b0, 1'b0, "R4");
      // R6: undervoltage warning alone keeps the device trusted
      send_a({8'hF0, 8'h0F, 8'h99}, {gst(8'hF0), gst(8'h0F) & 8'hFE, gst(8'h99)}, 3'b000, 1'b0, 1'b0, "R6");
      // R8: own fault line of device 2
      send_a({8'h01, 8'h80, 8'hFF}, {gst(8'h01), gst(8'h80), gst(8'hFF)}, 3'b100, 1'b0, 1'b0, "R8");
      // R5: ignore mode hides uv and fault, CRC error still masks device 1
      send_a({8'h6D, 8'hB2, 8'h47}, {gst(8'h6D) & 8'hFA, gst(8'hB2) ^ 8'h80, gst(8'h47)}, 3'b100, 1'b1, 1'b0, "R5");
      // R9: second start in mid-frame ignored
      send_a({8'h33, 8'h66, 8'hCC}, {gst(8'h33), gst(8'h66), gst(8'hCC)}, 3'b000, 1'b0, 1'b1, "R9");
      repeat (LOW_A + 10) @(negedge clk);

      // R7: no status bytes, healthy
      send_b({8'h12, 8'hFE, 8'h00}, 1'b0, 1'b0, "R7");
      // R8: shared fault line masks every device
      send_b({8'hAB, 8'hCD, 8'hEF}, 1'b1, 1'b0, "R8");
      // R5: shared fault disregarded in ignore mode
      send_b({8'h9C, 8'h3E, 8'h71}, 1'b1, 1'b1, "R5");

      repeat (10) @(negedge clk);
      chk(n_done_a == n_exp_a, "R9", "frames on A", 32'(n_done_a), 32'(n_exp_a));
      chk(n_done_b == n_exp_b, "R9", "frames on B", 32'(n_done_b), 32'(n_exp_b));
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule